// File: doc/BRIEF.md
# Setpoint-Driven Step Pulse Generator

This block drives one stepper axis. A motion setpoint arrives as four 32-bit words presented together with a load strobe. The block takes its fields from those words (a 16-bit step count, a 23-bit divider that sets the step period, a direction bit and a 5-bit drive number) and keeps them in a local register. It then waits for a start pulse, emits the requested number of step pulses at the programmed rate with a steady direction level, and marks completion with a one-cycle done pulse.

A load can also request repeat-N execution. The held setpoint then stays armed and runs again on each later start pulse, until the N-th run finishes and a finished flag rises. An abort input stops output at once and empties the register, and still produces a done pulse. A pause input freezes every output for as long as it is held high.

The control is one finite state machine with four states. `EMPTY` means no setpoint is held. `ARMED` means a setpoint is held and the block is ready. `RUN` means pulses are being generated. `HOLD` means a run is frozen by pause. The transitions are: load (`EMPTY`→`ARMED`, and a reload while in `ARMED`); start (`ARMED`→`RUN`, or a direct completion when the count is zero); pause (`RUN`→`HOLD`); release (`HOLD`→`RUN` once pause is low again); complete (`RUN`→`ARMED` while repeat runs remain, otherwise `RUN`→`EMPTY`); abort (any state→`EMPTY`).

Top module: `step_pulse_gen`

## Requirements
- R1: Field placement: step count = {wd0_i[1:0], wd3_i[31:18]}; divider = {wd1_i[25:21], wd3_i[17:0]}; direction = wd1_i[26]; drive number = wd1_i[31:27]. The drive number appears on drive_o while a setpoint is held.
- R2: ready_o is high exactly while a setpoint is held and no run is in progress (state `ARMED`). It is low during a run. After a non-repeat run it stays low until the next load.
- R3: The effective period is max(divider, 2) cycles. Each step is high for period/2 cycles (rounded down), then low for the rest of the period. The first step goes high in the cycle after the clock edge that samples start.
- R4: done_o pulses for one cycle, count×period cycles after the start edge. A count of zero gives done in the cycle after the start edge, with no step pulse.
- R5: dir_o follows the loaded direction bit from the cycle after the load. It stays unchanged for the whole run and reads 0 when no setpoint is held.
- R6: With rep_en_i high at load, the setpoint runs again on each start, up to rep_n_i runs (0 counts as 1). tune_fin_o rises together with the done pulse of the last run. It stays high until the next load or abort. ready_o is high again after each earlier run.
- R7: One cycle after abort_i is sampled: done_o is high for one cycle; step_o, dir_o, ready_o, tune_fin_o and drive_o are low; the register is empty, so a later start produces no pulses.
- R8: While pause_i is high during a run, step_o and the remaining work are frozen. The run resumes when pause_i falls. A pause sampled on P clock edges delays done by P+1 cycles.
- R9: A start while no setpoint is held has no effect. A load during a run has no effect on the run in progress.
- R10: After reset, step_o, dir_o, ready_o, done_o and tune_fin_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture the four setpoint words |
| wd0_i | input | WORD_W | Setpoint word 0 |
| wd1_i | input | WORD_W | Setpoint word 1 |
| wd2_i | input | WORD_W | Setpoint word 2 (no field used here) |
| wd3_i | input | WORD_W | Setpoint word 3 |
| start_i | input | 1 | Begin a run of the held setpoint |
| abort_i | input | 1 | Stop at once and empty the register |
| pause_i | input | 1 | Freeze the run while high |
| rep_en_i | input | 1 | Request repeat execution (sampled at load) |
| rep_n_i | input | REP_W | Number of repeat runs (sampled at load) |
| step_o | output | 1 | Step pulse |
| dir_o | output | 1 | Direction level |
| ready_o | output | 1 | Setpoint held and idle |
| done_o | output | 1 | One-cycle completion pulse |
| tune_fin_o | output | 1 | Repeat series finished |
| drive_o | output | 5 | Drive number of the held setpoint |

## Verification
Every result is timed from the clock edge that samples the stimulus. ready_o, dir_o and drive_o are valid one cycle after a load. The first step is high one cycle after the start edge. done_o arrives count×period cycles after the start edge, plus P+1 cycles when a pause was sampled on P edges. The abort effects are visible one cycle after the abort edge. The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the start edge, so the done pulse is expected at index count×period+1. Pulse width is checked by counting high samples and rising edges over the run.

// File: rtl/spg_pkg.sv
package spg_pkg;

    localparam int SPG_CNT_W = 16;
    localparam int SPG_DIV_W = 23;
    localparam int SPG_DRV_W = 5;

    typedef enum logic [1:0] {
        SP_EMPTY = 2'd0,
        SP_ARMED = 2'd1,
        SP_RUN   = 2'd2,
        SP_HOLD  = 2'd3
    } spg_state_e;

    typedef struct packed {
        logic [SPG_DRV_W-1:0] drive;
        logic                 dir;
        logic [SPG_DIV_W-1:0] div;
        logic [SPG_CNT_W-1:0] cnt;
    } spg_setpoint_t;

endpackage

// File: rtl/spg_unpack.sv
module spg_unpack
    import spg_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] w0_i,
    input  logic [WORD_W-1:0] w1_i,
    input  logic [WORD_W-1:0] w2_i,
    input  logic [WORD_W-1:0] w3_i,
    output spg_setpoint_t     sp_o
);
    // Bits taken from each word for the split fields.
    localparam int CNT_LO_W = 14;
    localparam int CNT_HI_W = SPG_CNT_W - CNT_LO_W;
    localparam int DIV_LO_W = 18;
    localparam int DIV_HI_W = SPG_DIV_W - DIV_LO_W;
    localparam int DIR_BIT  = 26;
    localparam int DIVH_LSB = DIR_BIT - DIV_HI_W;
    localparam int DRV_LSB  = DIR_BIT + 1;

    logic unused_w2;
    assign unused_w2 = ^w2_i;

    always_comb begin
        sp_o.cnt   = {w0_i[CNT_HI_W-1:0], w3_i[WORD_W-1 -: CNT_LO_W]};
        sp_o.div   = {w1_i[DIVH_LSB +: DIV_HI_W], w3_i[DIV_LO_W-1:0]};
        sp_o.dir   = w1_i[DIR_BIT];
        sp_o.drive = w1_i[DRV_LSB +: SPG_DRV_W];
    end

endmodule

// File: rtl/spg_phase.sv
module spg_phase #(
    parameter int DIV_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             wrap_o,
    output logic             level_o
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] ph_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] hi_len;

    always_comb begin
        div_eff = (div_i < MIN_DIV) ? MIN_DIV : div_i;
        hi_len  = div_eff >> 1;
        wrap_o  = (ph_q == div_eff - DIV_W'(1));
        level_o = (ph_q < hi_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (clr_i) begin
            ph_q <= '0;
        end else if (adv_i) begin
            ph_q <= wrap_o ? '0 : ph_q + DIV_W'(1);
        end
    end

    // R3: the phase never leaves the programmed period while advancing
    p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (ph_q < div_eff));

endmodule

// File: rtl/spg_repeat.sv
module spg_repeat #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [REP_W-1:0] n_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic             last_o
);
    localparam int CW = REP_W + 1;

    logic [CW-1:0] n_q;
    logic [CW-1:0] done_q;

    assign last_o = ((done_q + CW'(1)) >= n_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= CW'(1);
            done_q <= '0;
        end else if (clr_i) begin
            n_q    <= CW'(1);
            done_q <= '0;
        end else if (load_i) begin
            n_q    <= (n_i == '0) ? CW'(1) : CW'(n_i);
            done_q <= '0;
        end else if (inc_i && !last_o) begin
            done_q <= done_q + CW'(1);
        end
    end

    // R6: completed runs never reach the requested total while more remain
    p_rep_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q < n_q);

endmodule

// File: rtl/step_pulse_gen.sv
module step_pulse_gen
    import spg_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int REP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] wd0_i,
    input  logic [WORD_W-1:0] wd1_i,
    input  logic [WORD_W-1:0] wd2_i,
    input  logic [WORD_W-1:0] wd3_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              pause_i,
    input  logic              rep_en_i,
    input  logic [REP_W-1:0]  rep_n_i,
    output logic              step_o,
    output logic              dir_o,
    output logic              ready_o,
    output logic              done_o,
    output logic              tune_fin_o,
    output logic [4:0]        drive_o
);
    spg_state_e              state_q, state_d;
    spg_setpoint_t           sp_in, sp_q;
    logic [SPG_CNT_W-1:0]    remain_q;
    logic                    done_q, fin_q, rep_en_q;
    logic                    take_load, start_run, adv, complete;
    logic                    wrap, level, last_run, busy;

    spg_unpack #(.WORD_W(WORD_W)) u_unpack (
        .w0_i (wd0_i),
        .w1_i (wd1_i),
        .w2_i (wd2_i),
        .w3_i (wd3_i),
        .sp_o (sp_in)
    );

    spg_phase #(.DIV_W(SPG_DIV_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (start_run | abort_i),
        .adv_i   (adv),
        .div_i   (sp_q.div),
        .wrap_o  (wrap),
        .level_o (level)
    );

    spg_repeat #(.REP_W(REP_W)) u_repeat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (take_load),
        .n_i    (rep_n_i),
        .clr_i  (abort_i),
        .inc_i  (complete),
        .last_o (last_run)
    );

    // Next-state and control decode
    always_comb begin
        state_d   = state_q;
        take_load = 1'b0;
        start_run = 1'b0;
        adv       = 1'b0;
        complete  = 1'b0;
        if (abort_i) begin
            state_d = SP_EMPTY;
        end else begin
            unique case (state_q)
                SP_EMPTY: begin
                    if (load_i) begin
                        take_load = 1'b1;
                        state_d   = SP_ARMED;
                    end
                end
                SP_ARMED: begin
                    if (load_i) begin
                        take_load = 1'b1;
                    end else if (start_i) begin
                        if (sp_q.cnt == '0) begin
                            complete = 1'b1;
                        end else begin
                            start_run = 1'b1;
                            state_d   = SP_RUN;
                        end
                    end
                end
                SP_RUN: begin
                    if (pause_i) begin
                        state_d = SP_HOLD;
                    end else begin
                        adv = 1'b1;
                        if (wrap && remain_q == SPG_CNT_W'(1)) begin
                            complete = 1'b1;
                        end
                    end
                end
                SP_HOLD: begin
                    if (!pause_i) begin
                        state_d = SP_RUN;
                    end
                end
                default: state_d = SP_EMPTY;
            endcase
            if (complete) begin
                state_d = (rep_en_q && !last_run) ? SP_ARMED : SP_EMPTY;
            end
        end
    end

    // State and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SP_EMPTY;
            sp_q     <= '0;
            remain_q <= '0;
            done_q   <= 1'b0;
            fin_q    <= 1'b0;
            rep_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= abort_i | complete;
            if (abort_i) begin
                sp_q     <= '0;
                remain_q <= '0;
                fin_q    <= 1'b0;
                rep_en_q <= 1'b0;
            end else if (take_load) begin
                sp_q     <= sp_in;
                fin_q    <= 1'b0;
                rep_en_q <= rep_en_i;
            end else begin
                if (start_run) begin
                    remain_q <= sp_q.cnt;
                end else if (adv && wrap) begin
                    remain_q <= remain_q - SPG_CNT_W'(1);
                end
                if (complete && state_d == SP_EMPTY) begin
                    sp_q <= '0;
                end
                if (complete && rep_en_q && last_run) begin
                    fin_q <= 1'b1;
                end
            end
        end
    end

    // Output decode
    always_comb begin
        busy       = (state_q == SP_RUN) || (state_q == SP_HOLD);
        step_o     = busy && level;
        dir_o      = sp_q.dir;
        drive_o    = sp_q.drive;
        ready_o    = (state_q == SP_ARMED);
        done_o     = done_q;
        tune_fin_o = fin_q;
    end

    // R7: an abort always yields a done pulse on the next cycle
    p_abort_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> done_o);

    // R7: an abort leaves every output low apart from done
    p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!step_o && !ready_o && !dir_o && !tune_fin_o));

    // R8: a held pause freezes the step level and the remaining count
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SP_HOLD && pause_i && !abort_i) |=> ($stable(step_o) && $stable(remain_q)));

    // R5: direction does not move between consecutive busy cycles
    p_dir_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir_o));

    // R6: the finished flag only rises together with a done pulse
    p_fin_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tune_fin_o) |-> done_o);

    // R2: ready and a high step never coincide
    p_ready_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !step_o);

endmodule

// File: tb/step_pulse_gen_tb.sv
module step_pulse_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0, start_i = 1'b0, abort_i = 1'b0, pause_i = 1'b0;
    logic        rep_en_i = 1'b0;
    logic [7:0]  rep_n_i = '0;
    logic [31:0] wd0_i = '0, wd1_i = '0, wd2_i = '0, wd3_i = '0;
    logic        step_o, dir_o, ready_o, done_o, tune_fin_o;
    logic [4:0]  drive_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    step_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .wd0_i(wd0_i), .wd1_i(wd1_i), .wd2_i(wd2_i), .wd3_i(wd3_i),
        .start_i(start_i), .abort_i(abort_i), .pause_i(pause_i),
        .rep_en_i(rep_en_i), .rep_n_i(rep_n_i),
        .step_o(step_o), .dir_o(dir_o), .ready_o(ready_o), .done_o(done_o),
        .tune_fin_o(tune_fin_o), .drive_o(drive_o)
    );

    localparam int TV_N = 7;
    localparam logic [15:0] TV_CNT [TV_N] = '{16'd3, 16'd5, 16'd2, 16'd4, 16'd0, 16'd1, 16'h4001};
    localparam logic [22:0] TV_DIV [TV_N] = '{23'd4, 23'd2, 23'd7, 23'd1, 23'd5, 23'h040003, 23'd2};
    localparam logic        TV_DIR [TV_N] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [4:0]  TV_DRV [TV_N] = '{5'd17, 5'd3, 5'd31, 5'd0, 5'd9, 5'd22, 5'd5};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1: bench-side placement of the fields into the four words
    task automatic put_words(input logic [15:0] c, input logic [22:0] d,
                             input logic dr, input logic [4:0] drv);
        wd0_i = {30'h2AAAAAAA, c[15:14]};
        wd1_i = {drv, dr, d[22:18], 21'h15555};
        wd2_i = 32'h5A5A5A5A;
        wd3_i = {c[13:0], d[17:0]};
    endtask

    task automatic do_load(input logic [15:0] c, input logic [22:0] d, input logic dr,
                           input logic [4:0] drv, input logic ren, input logic [7:0] rn);
        put_words(c, d, dr, drv);
        rep_en_i = ren;
        rep_n_i  = rn;
        load_i   = 1'b1;
        @(negedge clk);
        load_i   = 1'b0;
    endtask

    // Pulse start, then count falling edges until done; returns index, rises, highs.
    task automatic run_measure(output int t, output int rises, output int highs);
        logic prev;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t = 1; rises = 0; highs = 0; prev = 1'b0;
        while (!done_o && t < 150000) begin
            if (step_o) highs++;
            if (step_o && !prev) rises++;
            prev = step_o;
            @(negedge clk);
            t++;
        end
    endtask

    function automatic int eff(input logic [22:0] d);
        return (d < 23'd2) ? 2 : int'(d);
    endfunction

    initial begin
        #(200000 * 10);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int t, r, h, p, sv;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!step_o && !dir_o && !ready_o && !done_o && !tune_fin_o, "R10 reset outputs",
            int'({step_o, dir_o, ready_o, done_o, tune_fin_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: start with an empty register
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        h = 0;
        for (int i = 0; i < 10; i++) begin
            if (step_o || done_o || ready_o) h++;
            @(negedge clk);
        end
        chk(h == 0, "R9 start while empty", h, 0);

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < TV_N; v++) begin
            do_load(TV_CNT[v], TV_DIV[v], TV_DIR[v], TV_DRV[v], 1'b0, 8'd0);
            chk(ready_o, "R2 ready after load", int'(ready_o), 1);
            chk(dir_o == TV_DIR[v], "R5 dir after load", int'(dir_o), int'(TV_DIR[v]));
            chk(drive_o == TV_DRV[v], "R1 drive number", int'(drive_o), int'(TV_DRV[v]));
            if (TV_DIV[v] > 23'd1000) begin
                // R1: large divider from the high field bits; check the first step only
                start_i = 1'b1; @(negedge clk); start_i = 1'b0;
                chk(!ready_o, "R2 ready low in run", int'(ready_o), 0);
                h = 0;
                for (int i = 0; i < 200; i++) begin
                    if (step_o) h++;
                    @(negedge clk);
                end
                chk(h == 200, "R1 R3 divider high part", h, 200);
                abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
                @(negedge clk);
            end else begin
                run_measure(t, r, h);
                chk(t == int'(TV_CNT[v]) * eff(TV_DIV[v]) + 1, "R4 done timing", t,
                    int'(TV_CNT[v]) * eff(TV_DIV[v]) + 1);
                chk(r == int'(TV_CNT[v]), "R3 pulse count", r, int'(TV_CNT[v]));
                chk(h == int'(TV_CNT[v]) * (eff(TV_DIV[v]) / 2), "R3 pulse width", h,
                    int'(TV_CNT[v]) * (eff(TV_DIV[v]) / 2));
                chk(!ready_o, "R2 ready low after run", int'(ready_o), 0);
                @(negedge clk);
                chk(!done_o, "R4 done one cycle", int'(done_o), 0);
                chk(!dir_o, "R5 dir cleared when empty", int'(dir_o), 0);
            end
        end

        // R6: repeat three times
        do_load(16'd2, 23'd3, 1'b1, 5'd4, 1'b1, 8'd3);
        for (int k = 0; k < 3; k++) begin
            run_measure(t, r, h);
            chk(t == 7, "R6 repeat run timing", t, 7);
            chk(tune_fin_o == (k == 2), "R6 finished flag", int'(tune_fin_o), int'(k == 2));
            chk(ready_o == (k < 2), "R6 ready between runs", int'(ready_o), int'(k < 2));
            @(negedge clk);
        end
        chk(tune_fin_o, "R6 finished flag held", int'(tune_fin_o), 1);
        do_load(16'd1, 23'd2, 1'b0, 5'd1, 1'b0, 8'd0);
        chk(!tune_fin_o, "R6 finished flag cleared by load", int'(tune_fin_o), 0);
        run_measure(t, r, h);
        @(negedge clk);

        // R6: repeat count of zero acts as one
        do_load(16'd1, 23'd2, 1'b0, 5'd1, 1'b1, 8'd0);
        run_measure(t, r, h);
        chk(tune_fin_o && !ready_o, "R6 zero count is one run", int'(tune_fin_o), 1);
        @(negedge clk);

        // R8: pause
        do_load(16'd4, 23'd4, 1'b1, 5'd6, 1'b0, 8'd0);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        t = 1;
        repeat (4) begin @(negedge clk); t++; end
        pause_i = 1'b1;
        sv = int'(step_o);
        p = 0;
        repeat (3) begin
            @(negedge clk); t++;
            if (int'(step_o) != sv) p++;
        end
        chk(p == 0, "R8 step frozen in pause", p, 0);
        pause_i = 1'b0;
        while (!done_o && t < 1000) begin @(negedge clk); t++; end
        chk(t == 16 + 3 + 1 + 1, "R8 pause delays done", t, 21);
        @(negedge clk);

        // R9: load during a run is ignored
        do_load(16'd3, 23'd4, 1'b1, 5'd7, 1'b0, 8'd0);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        t = 1;
        repeat (2) begin @(negedge clk); t++; end
        put_words(16'd1, 23'd2, 1'b0, 5'd2);
        load_i = 1'b1; @(negedge clk); t++; load_i = 1'b0;
        chk(dir_o == 1'b1 && drive_o == 5'd7, "R9 load in run ignored", int'(drive_o), 7);
        while (!done_o && t < 1000) begin @(negedge clk); t++; end
        chk(t == 13, "R9 run unchanged by load", t, 13);
        @(negedge clk);

        // R7: abort in mid-run
        do_load(16'd10, 23'd4, 1'b1, 5'd12, 1'b1, 8'd5);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        repeat (6) @(negedge clk);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        chk(done_o, "R7 done after abort", int'(done_o), 1);
        chk(!step_o && !dir_o && !ready_o && !tune_fin_o && drive_o == 5'd0,
            "R7 outputs cleared", int'({step_o, dir_o, ready_o, tune_fin_o}), 0);
        @(negedge clk);
        chk(!done_o, "R7 done single cycle", int'(done_o), 0);
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        h = 0;
        for (int i = 0; i < 12; i++) begin
            if (step_o || done_o) h++;
            @(negedge clk);
        end
        chk(h == 0, "R7 register emptied", h, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule